// File: doc/BRIEF.md
# Critical-Word-First Instruction Line Fill Controller

This block sits between an instruction fetch requester and an external read port. It holds a direct-mapped array of 32-byte lines, each made of four 64-bit words, with a valid bit and a tag per line. For each fetch request it looks up the indexed line. Only a line whose valid bit is set can match. A hit also needs the memory to be enabled, cache mode to be selected, and the request to be marked cacheable. On a hit, the requested word comes back one cycle after the request is accepted.

On a miss, the block issues one burst read of four 64-bit beats on the external port. The burst starts at the missed word rather than at the line base. The memory returns that word first and then the rest of the line in ascending order, wrapping within the aligned line. The requester is stalled only until the first beat arrives, and that beat is forwarded at once. The line is filled in the background, and its valid bit is set once the fourth beat has been written.

Every word delivered to the requester is also loaded into one of two 64-bit holding buffers, alternating between them. A fetch-alignment stage downstream can read these buffers. When the qualifiers forbid caching, a miss still runs the burst and returns the target word, but the array is left unchanged.

Top module: `icf_line_fill`

## Requirements
- R1: The address splits into a byte offset in bits [2:0], a word offset in bits [4:3], a line index in bits [IDX_W+4:5] and a tag in the bits above, so each line holds four 64-bit words.
- R2: A line whose valid bit is clear never produces a hit. A synchronous reset clears every valid bit, so after reset any address misses.
- R3: A hit needs `cfg_mem_en`, `cfg_cache_mode` and `req_cacheable` all high. If any of them is low, the access is a bypass. A bypass runs the burst and returns the first beat, but writes nothing into the array and changes no valid bit.
- R4: A request accepted on a hit gives `rsp_valid`=1, `rsp_hit`=1 and the stored word on `rsp_data` in the next cycle.
- R5: On a miss, the cycle after acceptance raises `mem_req_valid`. It carries `mem_req_addr` equal to the request address and `mem_req_len`=4. Both stay unchanged until `mem_req_ready` is seen high.
- R6: Beat k of a burst (k = 0..3) is written into word ((s + k) mod 4) of the line, where s is the missed word offset.
- R7: `stall` is high from the cycle after a miss is accepted until the first beat is taken. In the cycle after that beat, `stall` is low and `rsp_valid`=1 with `rsp_hit`=0 and `rsp_data` equal to that beat.
- R8: `req_ready` is low from a miss acceptance until the fourth beat has been taken. It is high again in the following cycle.
- R9: The valid bit of the line being allocated is cleared when its fill starts and is set only after the fourth beat. From then on, hits to the new tag return the burst data, and the previous tag of that line misses.
- R10: Each word delivered on `rsp_data` is also loaded into holding buffer `hold_sel`, and `hold_sel` then toggles. After reset both buffers are zero and `hold_sel`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_mem_en | input | 1 | Instruction memory enable |
| cfg_cache_mode | input | 1 | Memory configured as cache |
| req_valid | input | 1 | Fetch request present |
| req_ready | output | 1 | Request can be accepted (no fill in progress) |
| req_addr | input | ADDR_W | Fetch byte address |
| req_cacheable | input | 1 | Page of this fetch is cacheable |
| stall | output | 1 | Requester must wait for the critical word |
| rsp_valid | output | 1 | Response word present |
| rsp_hit | output | 1 | Response came from the array (1) or the external port (0) |
| rsp_data | output | 64 | Response word |
| hold_buf0 | output | 64 | Holding buffer 0 |
| hold_buf1 | output | 64 | Holding buffer 1 |
| hold_sel | output | 1 | Buffer that the next delivered word will load |
| mem_req_valid | output | 1 | Burst read request |
| mem_req_ready | input | 1 | External port accepts the request |
| mem_req_addr | output | ADDR_W | Burst start address (the missed word) |
| mem_req_len | output | 3 | Burst length in beats, always 4 |
| mem_rd_valid | input | 1 | Read beat present |
| mem_rd_data | input | 64 | Read beat data |

## Verification
A beat written into the wrong word stays hidden until that word is fetched again. It then shows as a wrong `rsp_data` one cycle after a hit, so every word of each filled line is read back for every starting offset. A valid bit that is set too early or left stale shows up as `rsp_hit` in the cycle after acceptance, where `mem_req_valid` should have risen instead. A fault in qualifier decoding shows the same way, while an allocation during a bypass only shows on a later hit to that line. A fault in the fill sequencer shows within a cycle of the beat concerned, as a wrongly timed `stall` or `req_ready` edge.

// File: rtl/icf_pkg.sv
package icf_pkg;

    localparam int WORD_W     = 64;
    localparam int BOFF_W     = 3;
    localparam int WOFF_W     = 2;
    localparam int LINE_WORDS = 1 << WOFF_W;
    localparam int LINE_OFF_W = BOFF_W + WOFF_W;
    localparam int LEN_W      = 3;
    localparam logic [LEN_W-1:0] BURST_LEN = LEN_W'(LINE_WORDS);

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [WOFF_W-1:0] woff_t;

    typedef enum logic [1:0] {
        FS_IDLE = 2'd0,
        FS_REQ  = 2'd1,
        FS_FILL = 2'd2
    } fill_state_e;

    typedef struct packed {
        logic  hit;
        word_t data;
    } rsp_t;

    // word slot hit by beat k of a burst starting at word s
    function automatic woff_t wrap_word(input woff_t s, input woff_t k);
        return s + k;
    endfunction

endpackage

// File: rtl/icf_tag_store.sv
module icf_tag_store #(
    parameter int IDX_W = 4,
    parameter int TAG_W = 23
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] lk_idx,
    input  logic [TAG_W-1:0] lk_tag,
    output logic             lk_match,
    input  logic             inv_en,
    input  logic [IDX_W-1:0] inv_idx,
    input  logic             set_en,
    input  logic [IDX_W-1:0] set_idx,
    input  logic [TAG_W-1:0] set_tag
);
    localparam int LINES = 1 << IDX_W;

    logic             vld_q [LINES];
    logic [TAG_W-1:0] tag_q [LINES];

    for (genvar g = 0; g < LINES; g++) begin : g_line
        always_ff @(posedge clk) begin
            if (rst) begin
                vld_q[g] <= 1'b0;
            end else if (set_en && set_idx == IDX_W'(g)) begin
                vld_q[g] <= 1'b1;
            end else if (inv_en && inv_idx == IDX_W'(g)) begin
                vld_q[g] <= 1'b0;
            end
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                tag_q[g] <= '0;
            end else if (set_en && set_idx == IDX_W'(g)) begin
                tag_q[g] <= set_tag;
            end
        end
    end

    // invalid lines are excluded from the compare
    assign lk_match = vld_q[lk_idx] && (tag_q[lk_idx] == lk_tag);

    // R9: a line is only validated after its fill cleared it
    a_r9_set_after_clear: assert property (@(posedge clk) disable iff (rst)
        set_en |-> !vld_q[set_idx]);

endmodule

// File: rtl/icf_data_store.sv
module icf_data_store #(
    parameter int IDX_W = 4
) (
    input  logic                clk,
    input  logic                wr_en,
    input  logic [IDX_W-1:0]    wr_idx,
    input  icf_pkg::woff_t      wr_word,
    input  icf_pkg::word_t      wr_data,
    input  logic [IDX_W-1:0]    rd_idx,
    input  icf_pkg::woff_t      rd_word,
    output icf_pkg::word_t      rd_data
);
    localparam int DEPTH = (1 << IDX_W) * icf_pkg::LINE_WORDS;

    icf_pkg::word_t mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem_q[{wr_idx, wr_word}] <= wr_data;
        end
    end

    assign rd_data = mem_q[{rd_idx, rd_word}];

endmodule

// File: rtl/icf_fill_seq.sv
module icf_fill_seq
    import icf_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] start_addr_i,
    input  logic              alloc_i,
    input  logic              mem_req_ready_i,
    input  logic              mem_rd_valid_i,
    output logic              busy_o,
    output logic              stall_o,
    output logic              mem_req_valid_o,
    output logic [ADDR_W-1:0] mem_req_addr_o,
    output logic              crit_beat_o,
    output logic              wr_en_o,
    output woff_t             wr_word_o,
    output logic              fill_done_o,
    output logic [IDX_W-1:0]  fill_idx_o,
    output logic [ADDR_W-LINE_OFF_W-IDX_W-1:0] fill_tag_o
);
    fill_state_e       state_q;
    logic [ADDR_W-1:0] addr_q;
    logic              alloc_q;
    woff_t             cnt_q;
    logic              crit_q;
    logic              beat;
    logic              last_beat;

    assign beat      = (state_q == FS_FILL) && mem_rd_valid_i;
    assign last_beat = beat && (cnt_q == woff_t'(LINE_WORDS - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= FS_IDLE;
            addr_q  <= '0;
            alloc_q <= 1'b0;
            cnt_q   <= '0;
            crit_q  <= 1'b0;
        end else begin
            unique case (state_q)
                FS_IDLE: begin
                    if (start_i) begin
                        state_q <= FS_REQ;
                        addr_q  <= start_addr_i;
                        alloc_q <= alloc_i;
                        cnt_q   <= '0;
                        crit_q  <= 1'b0;
                    end
                end
                FS_REQ: begin
                    if (mem_req_ready_i) begin
                        state_q <= FS_FILL;
                    end
                end
                FS_FILL: begin
                    if (beat) begin
                        cnt_q  <= cnt_q + 1'b1;
                        crit_q <= 1'b1;
                        if (last_beat) begin
                            state_q <= FS_IDLE;
                        end
                    end
                end
                default: state_q <= FS_IDLE;
            endcase
        end
    end

    assign busy_o          = (state_q != FS_IDLE);
    assign stall_o         = (state_q == FS_REQ) || ((state_q == FS_FILL) && !crit_q);
    assign mem_req_valid_o = (state_q == FS_REQ);
    assign mem_req_addr_o  = addr_q;
    assign crit_beat_o     = beat && (cnt_q == '0);
    assign wr_en_o         = beat && alloc_q;
    assign wr_word_o       = wrap_word(addr_q[LINE_OFF_W-1:BOFF_W], cnt_q);
    assign fill_done_o     = last_beat && alloc_q;
    assign fill_idx_o      = addr_q[LINE_OFF_W+IDX_W-1:LINE_OFF_W];
    assign fill_tag_o      = addr_q[ADDR_W-1:LINE_OFF_W+IDX_W];

    // R5: request and address held until accepted
    a_r5_req_held: assert property (@(posedge clk) disable iff (rst)
        (mem_req_valid_o && !mem_req_ready_i) |=> (mem_req_valid_o && $stable(mem_req_addr_o)));

    // R8: the block stays busy between beats of one burst
    a_r8_busy_mid_burst: assert property (@(posedge clk) disable iff (rst)
        (beat && !last_beat) |=> busy_o);

endmodule

// File: rtl/icf_line_fill.sv
module icf_line_fill
    import icf_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_mem_en,
    input  logic              cfg_cache_mode,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_cacheable,
    output logic              stall,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic [63:0]       rsp_data,
    output logic [63:0]       hold_buf0,
    output logic [63:0]       hold_buf1,
    output logic              hold_sel,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [ADDR_W-1:0] mem_req_addr,
    output logic [2:0]        mem_req_len,
    input  logic              mem_rd_valid,
    input  logic [63:0]       mem_rd_data
);
    localparam int TAG_W = ADDR_W - LINE_OFF_W - IDX_W;

    logic [IDX_W-1:0] lk_idx;
    logic [TAG_W-1:0] lk_tag;
    woff_t            lk_word;
    logic             lk_match;
    logic             qual_ok;
    logic             accept;
    logic             hit;
    word_t            arr_rd;

    logic             busy;
    logic             crit_beat;
    logic             wr_en;
    woff_t            wr_word;
    logic             fill_done;
    logic [IDX_W-1:0] fill_idx;
    logic [TAG_W-1:0] fill_tag;

    rsp_t             rsp_q;
    rsp_t             rsp_d;
    logic             rsp_load;
    logic             rsp_valid_q;
    logic             sel_q;
    word_t            hold_q [2];

    assign lk_word = req_addr[LINE_OFF_W-1:BOFF_W];
    assign lk_idx  = req_addr[LINE_OFF_W+IDX_W-1:LINE_OFF_W];
    assign lk_tag  = req_addr[ADDR_W-1:LINE_OFF_W+IDX_W];

    assign qual_ok = cfg_mem_en && cfg_cache_mode && req_cacheable;
    assign accept  = req_valid && req_ready;
    assign hit     = qual_ok && lk_match;

    icf_tag_store #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_tags (
        .clk      (clk),
        .rst      (rst),
        .lk_idx   (lk_idx),
        .lk_tag   (lk_tag),
        .lk_match (lk_match),
        .inv_en   (accept && !hit && qual_ok),
        .inv_idx  (lk_idx),
        .set_en   (fill_done),
        .set_idx  (fill_idx),
        .set_tag  (fill_tag)
    );

    icf_data_store #(.IDX_W(IDX_W)) u_data (
        .clk     (clk),
        .wr_en   (wr_en),
        .wr_idx  (fill_idx),
        .wr_word (wr_word),
        .wr_data (mem_rd_data),
        .rd_idx  (lk_idx),
        .rd_word (lk_word),
        .rd_data (arr_rd)
    );

    icf_fill_seq #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_seq (
        .clk             (clk),
        .rst             (rst),
        .start_i         (accept && !hit),
        .start_addr_i    (req_addr),
        .alloc_i         (qual_ok),
        .mem_req_ready_i (mem_req_ready),
        .mem_rd_valid_i  (mem_rd_valid),
        .busy_o          (busy),
        .stall_o         (stall),
        .mem_req_valid_o (mem_req_valid),
        .mem_req_addr_o  (mem_req_addr),
        .crit_beat_o     (crit_beat),
        .wr_en_o         (wr_en),
        .wr_word_o       (wr_word),
        .fill_done_o     (fill_done),
        .fill_idx_o      (fill_idx),
        .fill_tag_o      (fill_tag)
    );

    assign req_ready   = !busy;
    assign mem_req_len = BURST_LEN;

    // response source: array on a hit, critical beat on a fill
    assign rsp_load = (accept && hit) || crit_beat;
    always_comb begin
        rsp_d.hit  = !crit_beat;
        rsp_d.data = crit_beat ? mem_rd_data : arr_rd;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid_q <= 1'b0;
            rsp_q       <= '0;
        end else begin
            rsp_valid_q <= rsp_load;
            if (rsp_load) begin
                rsp_q <= rsp_d;
            end
        end
    end

    for (genvar b = 0; b < 2; b++) begin : g_hold
        always_ff @(posedge clk) begin
            if (rst) begin
                hold_q[b] <= '0;
            end else if (rsp_load && sel_q == b[0]) begin
                hold_q[b] <= rsp_d.data;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q <= 1'b0;
        end else if (rsp_load) begin
            sel_q <= !sel_q;
        end
    end

    assign rsp_valid = rsp_valid_q;
    assign rsp_hit   = rsp_q.hit;
    assign rsp_data  = rsp_q.data;
    assign hold_buf0 = hold_q[0];
    assign hold_buf1 = hold_q[1];
    assign hold_sel  = sel_q;

    // R3: a hit response only follows a fully qualified request
    a_r3_hit_qualified: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_hit) |-> ($past(cfg_mem_en) && $past(cfg_cache_mode) && $past(req_cacheable)));

    // R7: stall drops exactly when the critical word is presented
    a_r7_stall_release: assert property (@(posedge clk) disable iff (rst)
        $fell(stall) |-> (rsp_valid && !rsp_hit));

    // R8: no acceptance while the requester is stalled
    a_r8_no_accept_stalled: assert property (@(posedge clk) disable iff (rst)
        stall |-> !req_ready);

    // R10: every delivered word flips the buffer pointer
    a_r10_hold_toggle: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> (hold_sel != $past(hold_sel)));

endmodule

// File: tb/icf_line_fill_tb.sv
`timescale 1ns/1ps
module icf_line_fill_tb;

    logic        clk = 1'b0;
    logic        rst;
    logic        cfg_mem_en;
    logic        cfg_cache_mode;
    logic        req_valid;
    logic        req_ready;
    logic [31:0] req_addr;
    logic        req_cacheable;
    logic        stall;
    logic        rsp_valid;
    logic        rsp_hit;
    logic [63:0] rsp_data;
    logic [63:0] hold_buf0;
    logic [63:0] hold_buf1;
    logic        hold_sel;
    logic        mem_req_valid;
    logic        mem_req_ready;
    logic [31:0] mem_req_addr;
    logic [2:0]  mem_req_len;
    logic        mem_rd_valid;
    logic [63:0] mem_rd_data;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    logic [63:0] m_hold [2];
    logic        m_sel;

    always #2 clk = ~clk;

    icf_line_fill u_dut (
        .clk            (clk),
        .rst            (rst),
        .cfg_mem_en     (cfg_mem_en),
        .cfg_cache_mode (cfg_cache_mode),
        .req_valid      (req_valid),
        .req_ready      (req_ready),
        .req_addr       (req_addr),
        .req_cacheable  (req_cacheable),
        .stall          (stall),
        .rsp_valid      (rsp_valid),
        .rsp_hit        (rsp_hit),
        .rsp_data       (rsp_data),
        .hold_buf0      (hold_buf0),
        .hold_buf1      (hold_buf1),
        .hold_sel       (hold_sel),
        .mem_req_valid  (mem_req_valid),
        .mem_req_ready  (mem_req_ready),
        .mem_req_addr   (mem_req_addr),
        .mem_req_len    (mem_req_len),
        .mem_rd_valid   (mem_rd_valid),
        .mem_rd_data    (mem_rd_data)
    );

    function automatic logic [63:0] pat(input logic [31:0] a, input bit alt);
        logic [31:0] w;
        w = {a[31:3], 3'b000};
        return alt ? {w, w ^ 32'hFFFF_0000} : {w ^ 32'hC3C3_0000, ~w};
    endfunction

    // R1: tag above bit 8, index [8:5], word [4:3], byte [2:0]
    function automatic logic [31:0] mk(input logic [22:0] tag, input logic [3:0] idx,
                                       input logic [1:0] w, input logic [2:0] b);
        return {tag, idx, w, b};
    endfunction

    task automatic chk(input string r, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", r, act, exp);
        end
    endtask

    task automatic deliver(input logic [63:0] d);
        m_hold[m_sel] = d;
        m_sel = ~m_sel;
    endtask

    task automatic chk_hold(input string r);
        chk(r, {63'd0, hold_sel}, {63'd0, m_sel});
        chk(r, hold_buf0, m_hold[0]);
        chk(r, hold_buf1, m_hold[1]);
    endtask

    task automatic do_access(input logic [31:0] a, input logic cach, input logic en,
                             input logic cm, input bit exp_hit, input bit alt, input int gaps);
        logic [31:0] base;
        logic [1:0]  s;
        logic [31:0] ba;
        base = {a[31:5], 5'b0};
        s    = a[4:3];
        @(negedge clk);
        chk("R8 ready before request", {63'd0, req_ready}, 64'd1);
        req_valid      = 1'b1;
        req_addr       = a;
        req_cacheable  = cach;
        cfg_mem_en     = en;
        cfg_cache_mode = cm;
        @(negedge clk);
        req_valid = 1'b0;
        if (exp_hit) begin
            chk("R4 hit valid", {63'd0, rsp_valid}, 64'd1);
            chk("R4 hit flag", {63'd0, rsp_hit}, 64'd1);
            chk("R4 hit data", rsp_data, pat(a, 1'b0));
            deliver(pat(a, 1'b0));
        end else begin
            chk("R7 stall on miss", {63'd0, stall}, 64'd1);
            chk("R2 R3 no hit response", {63'd0, rsp_valid}, 64'd0);
            chk("R5 request valid", {63'd0, mem_req_valid}, 64'd1);
            chk("R5 request addr", {32'd0, mem_req_addr}, {32'd0, a});
            chk("R5 request len", {61'd0, mem_req_len}, 64'd4);
            mem_req_ready = 1'b0;
            @(negedge clk);
            chk("R5 request held", {63'd0, mem_req_valid}, 64'd1);
            chk("R5 addr held", {32'd0, mem_req_addr}, {32'd0, a});
            mem_req_ready = 1'b1;
            @(negedge clk);
            mem_req_ready = 1'b0;
            chk("R5 request dropped", {63'd0, mem_req_valid}, 64'd0);
            for (int k = 0; k < 4; k++) begin
                repeat (gaps) @(negedge clk);
                if (k == 0) chk("R7 stall until first beat", {63'd0, stall}, 64'd1);
                ba = base + {27'd0, 2'(s + 2'(k)), 3'b000};
                mem_rd_valid = 1'b1;
                mem_rd_data  = pat(ba, alt);
                @(negedge clk);
                mem_rd_valid = 1'b0;
                mem_rd_data  = '0;
                if (k == 0) begin
                    chk("R7 critical valid", {63'd0, rsp_valid}, 64'd1);
                    chk("R7 critical flag", {63'd0, rsp_hit}, 64'd0);
                    chk("R7 critical data", rsp_data, pat(a, alt));
                    chk("R7 stall released", {63'd0, stall}, 64'd0);
                    deliver(pat(a, alt));
                end else begin
                    chk("R7 single response", {63'd0, rsp_valid}, 64'd0);
                end
                chk("R8 ready during fill", {63'd0, req_ready}, (k < 3) ? 64'd0 : 64'd1);
            end
        end
        chk_hold("R10 holding buffers");
    endtask

    task automatic t_reset();
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        m_hold[0] = '0;
        m_hold[1] = '0;
        m_sel     = 1'b0;
        chk("R10 reset hold", {63'd0, hold_sel}, 64'd0);
        chk_hold("R10 reset buffers");
        chk("R8 reset ready", {63'd0, req_ready}, 64'd1);
        chk("R7 reset stall", {63'd0, stall}, 64'd0);
        chk("R4 reset rsp", {63'd0, rsp_valid}, 64'd0);
        chk("R5 reset mem req", {63'd0, mem_req_valid}, 64'd0);
    endtask

    // R6 R9: every starting offset, then read back every word
    task automatic t_all_offsets();
        for (int s = 0; s < 4; s++) begin
            do_access(mk(23'h1A0 + 23'(s), 4'(s + 2), 2'(s), 3'(s)), 1, 1, 1, 0, 0, s % 2);
            for (int w = 0; w < 4; w++) begin
                do_access(mk(23'h1A0 + 23'(s), 4'(s + 2), 2'(w), 3'd0), 1, 1, 1, 1, 0, 0);
            end
        end
    endtask

    // R3: each qualifier low gives a bypass with no allocation
    task automatic t_qualifiers();
        logic [31:0] a;
        a = mk(23'h0042, 4'd9, 2'd1, 3'd0);
        do_access(a, 1, 1, 1, 0, 0, 0);
        do_access(a, 0, 1, 1, 0, 1, 0);
        do_access(a, 1, 0, 1, 0, 1, 1);
        do_access(a, 1, 1, 0, 0, 1, 0);
        do_access(a, 1, 1, 1, 1, 0, 0);
        do_access(mk(23'h0042, 4'd9, 2'd3, 3'd0), 1, 1, 1, 1, 0, 0);
    endtask

    // R2 R9: replacing a line drops the old tag
    task automatic t_replace();
        do_access(mk(23'h0077, 4'd9, 2'd2, 3'd0), 1, 1, 1, 0, 0, 0);
        do_access(mk(23'h0077, 4'd9, 2'd0, 3'd0), 1, 1, 1, 1, 0, 0);
        do_access(mk(23'h0042, 4'd9, 2'd1, 3'd0), 1, 1, 1, 0, 0, 2);
    endtask

    // R2: reset invalidates a filled line
    task automatic t_reset_invalidates();
        t_reset();
        do_access(mk(23'h0042, 4'd9, 2'd1, 3'd0), 1, 1, 1, 0, 0, 0);
        do_access(mk(23'h0042, 4'd9, 2'd2, 3'd0), 1, 1, 1, 1, 0, 0);
    endtask

    task automatic report();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            report();
            $finish;
        end
    end

    initial begin
        rst = 1'b1;
        cfg_mem_en = 1'b0;
        cfg_cache_mode = 1'b0;
        req_valid = 1'b0;
        req_addr = '0;
        req_cacheable = 1'b0;
        mem_req_ready = 1'b0;
        mem_rd_valid = 1'b0;
        mem_rd_data = '0;
        m_hold[0] = '0;
        m_hold[1] = '0;
        m_sel = 1'b0;
        t_reset();
        t_all_offsets();
        t_qualifiers();
        t_replace();
        t_reset_invalidates();
        done = 1'b1;
        report();
        $finish;
    end

endmodule